// File: doc/BRIEF.md
# Push-Button HID Report and Suspend Control

This block sits between four front-panel buttons of a USB audio device and the USB function logic. The buttons are record mute, playback mute, volume up and volume down. Each raw button level is synchronised to the system clock and debounced, and the resulting edges update a four-bit HID input report. The record-mute button behaves as a toggle and holds its state. The other three buttons follow the filtered button level.

Whenever the report word changes, a one-cycle strobe is raised so that the USB side can queue an interrupt transfer. The block also turns the device's suspend request into the control levels for an external headphone amplifier and the microphone bias. It drives the record-mute status indicator and forces it low while the device is suspended.

Each debouncer is a four-state machine. `ST_LOW` moves to `ST_RISE_WAIT` when the synchronised input goes high. `ST_RISE_WAIT` returns to `ST_LOW` if the input drops, and moves to `ST_HIGH` with a rise pulse once the input has stayed high long enough. `ST_HIGH` moves to `ST_FALL_WAIT` when the input goes low. `ST_FALL_WAIT` returns to `ST_HIGH` if the input comes back, and moves to `ST_LOW` with a fall pulse once the input has stayed low long enough. The power controller has two states: `PWR_SUSPEND`, which is the reset state and is entered while the suspend request is high, and `PWR_NORMAL`, which is entered while the request is low.

Top module: `btn_hid_ctrl`

## Requirements
- R1: While reset is low and right after it is released, the report word is 0, the change strobe is 0 and the record-mute status output is low.
- R2: Each debounced rising edge of the record-mute button inverts report bit 0 (record-mute state). Its falling edge leaves the bit unchanged.
- R3: Report bit 1 (playback mute), bit 2 (volume up) and bit 3 (volume down) are set on the debounced rising edge of their button and cleared on its falling edge.
- R4: A button level that lasts fewer than DEBOUNCE_CYCLES clock cycles after synchronisation produces no report change and no strobe.
- R5: A button input held constantly low never produces a report change or a strobe.
- R6: The change strobe is high for exactly one cycle, and only in the cycle in which the report word takes a new value. Edges on several buttons in the same cycle give a single strobe.
- R7: The record-mute status output equals report bit 0 while the device is not suspended, and it is low during suspend.
- R8: One cycle after the suspend request is low, the amplifier power switch is 1, amplifier standby is 0 and microphone bias enable is 1. One cycle after the request is high, these outputs are 0, 1 and 0.
- R9: When not suspended, the amplifier mute output follows the host playback-mute input. In suspend it is forced to 1.
- R10: The record-mute state still toggles during suspend and shows on the status output once suspend ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_rec_mute_i | input | 1 | Raw record-mute button, active high |
| btn_play_mute_i | input | 1 | Raw playback-mute button, active high |
| btn_vol_up_i | input | 1 | Raw volume-up button, active high |
| btn_vol_down_i | input | 1 | Raw volume-down button, active high |
| suspend_i | input | 1 | Suspend request from the USB side |
| host_play_mute_i | input | 1 | Playback mute requested by the host |
| report_o | output | 4 | HID report: [0] record mute, [1] playback mute, [2] volume up, [3] volume down |
| report_chg_o | output | 1 | One-cycle strobe when report_o changes |
| rec_mute_stat_o | output | 1 | Record-mute status indicator |
| amp_pwr_o | output | 1 | Amplifier power switch, high when running |
| amp_stby_o | output | 1 | Amplifier standby, high in suspend |
| amp_mute_o | output | 1 | Amplifier mute, high when muted |
| mic_bias_en_o | output | 1 | Microphone bias enable, low in suspend |

## Verification
The bench builds the block with DEBOUNCE_CYCLES set to 4 instead of a millisecond's worth of clocks. This makes every debounce window only a few cycles long. As a result, the full rise and fall paths of all four buttons, a glitch one window short, simultaneous edges on two buttons, and toggling during suspend all fit into a short run. The strobe is counted cycle by cycle, so a pulse that is too wide or doubled shows up as a wrong count.

// File: rtl/btn_hid_pkg.sv
package btn_hid_pkg;

    localparam int unsigned NUM_BTN  = 4;
    localparam int unsigned IDX_REC  = 0;
    localparam int unsigned IDX_PLAY = 1;
    localparam int unsigned IDX_VUP  = 2;
    localparam int unsigned IDX_VDN  = 3;

    typedef enum logic [1:0] {
        ST_LOW       = 2'd0,
        ST_RISE_WAIT = 2'd1,
        ST_HIGH      = 2'd2,
        ST_FALL_WAIT = 2'd3
    } db_state_t;

    typedef enum logic {
        PWR_SUSPEND = 1'b0,
        PWR_NORMAL  = 1'b1
    } pwr_state_t;

endpackage

// File: rtl/btn_debounce.sv
module btn_debounce
    import btn_hid_pkg::*;
#(
    parameter int unsigned DEBOUNCE_CYCLES = 48000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int unsigned CW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

    logic          sync1_q, sync2_q;
    db_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOW: begin
                cnt_d = '0;
                if (sync2_q) state_d = ST_RISE_WAIT;
            end
            ST_RISE_WAIT: begin
                if (!sync2_q) begin
                    state_d = ST_LOW;
                end else if (cnt_q == LAST) begin
                    state_d = ST_HIGH;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HIGH: begin
                cnt_d = '0;
                if (!sync2_q) state_d = ST_FALL_WAIT;
            end
            ST_FALL_WAIT: begin
                if (sync2_q) begin
                    state_d = ST_HIGH;
                end else if (cnt_q == LAST) begin
                    state_d = ST_LOW;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_LOW;
        endcase
    end

    // outputs
    always_comb begin
        level_o = 1'b0;
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        unique case (state_q)
            ST_LOW:       level_o = 1'b0;
            ST_RISE_WAIT: rise_o  = sync2_q && (cnt_q == LAST);
            ST_HIGH:      level_o = 1'b1;
            ST_FALL_WAIT: begin
                level_o = 1'b1;
                fall_o  = !sync2_q && (cnt_q == LAST);
            end
            default:      level_o = 1'b0;
        endcase
    end

    AST_RISE_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> level_o && !rise_o); // R4
    AST_FALL_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !level_o && !fall_o); // R4

endmodule

// File: rtl/mute_power_ctrl.sv
module mute_power_ctrl
    import btn_hid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic suspend_i,
    input  logic host_mute_i,
    input  logic rec_mute_i,
    output logic rec_stat_o,
    output logic amp_pwr_o,
    output logic amp_stby_o,
    output logic amp_mute_o,
    output logic mic_bias_o
);

    pwr_state_t state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_SUSPEND;
        else        state_q <= suspend_i ? PWR_SUSPEND : PWR_NORMAL;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PWR_NORMAL: begin
                rec_stat_o = rec_mute_i;
                amp_pwr_o  = 1'b1;
                amp_stby_o = 1'b0;
                amp_mute_o = host_mute_i;
                mic_bias_o = 1'b1;
            end
            default: begin
                rec_stat_o = 1'b0;
                amp_pwr_o  = 1'b0;
                amp_stby_o = 1'b1;
                amp_mute_o = 1'b1;
                mic_bias_o = 1'b0;
            end
        endcase
    end

    AST_SUSP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(suspend_i) |-> !amp_pwr_o && amp_stby_o && amp_mute_o && !mic_bias_o); // R8
    AST_NORM_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(suspend_i) |-> amp_pwr_o && !amp_stby_o && mic_bias_o); // R8
    AST_STAT_SUSP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(suspend_i) |-> !rec_stat_o); // R7

endmodule

// File: rtl/btn_hid_ctrl.sv
module btn_hid_ctrl
    import btn_hid_pkg::*;
#(
    parameter int unsigned DEBOUNCE_CYCLES = 48000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn_rec_mute_i,
    input  logic               btn_play_mute_i,
    input  logic               btn_vol_up_i,
    input  logic               btn_vol_down_i,
    input  logic               suspend_i,
    input  logic               host_play_mute_i,
    output logic [NUM_BTN-1:0] report_o,
    output logic               report_chg_o,
    output logic               rec_mute_stat_o,
    output logic               amp_pwr_o,
    output logic               amp_stby_o,
    output logic               amp_mute_o,
    output logic               mic_bias_en_o
);

    logic [NUM_BTN-1:0] raw, rise, fall, level;
    logic [NUM_BTN-1:0] report_q, report_d;
    logic               chg_q;

    assign raw[IDX_REC]  = btn_rec_mute_i;
    assign raw[IDX_PLAY] = btn_play_mute_i;
    assign raw[IDX_VUP]  = btn_vol_up_i;
    assign raw[IDX_VDN]  = btn_vol_down_i;

    for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
        btn_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw[g]),
            .level_o(level[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    always_comb begin
        report_d = report_q;
        for (int i = 0; i < NUM_BTN; i++) begin
            if (i == IDX_REC) begin
                if (rise[i]) report_d[i] = !report_q[i];
            end else if (rise[i]) begin
                report_d[i] = 1'b1;
            end else if (fall[i]) begin
                report_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            report_q <= '0;
            chg_q    <= 1'b0;
        end else begin
            report_q <= report_d;
            chg_q    <= (report_d != report_q);
        end
    end

    assign report_o     = report_q;
    assign report_chg_o = chg_q;

    mute_power_ctrl u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .suspend_i  (suspend_i),
        .host_mute_i(host_play_mute_i),
        .rec_mute_i (report_q[IDX_REC]),
        .rec_stat_o (rec_mute_stat_o),
        .amp_pwr_o  (amp_pwr_o),
        .amp_stby_o (amp_stby_o),
        .amp_mute_o (amp_mute_o),
        .mic_bias_o (mic_bias_en_o)
    );

    AST_REC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise[IDX_REC] |=> report_o[IDX_REC] != $past(report_o[IDX_REC])); // R2
    AST_REC_FALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fall[IDX_REC] |=> $stable(report_o[IDX_REC])); // R2
    AST_CHG_ON_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        (report_o != $past(report_o)) |-> report_chg_o); // R6
    AST_CHG_ONLY_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        report_chg_o |-> (report_o != $past(report_o))); // R6
    AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!level[IDX_PLAY] && !$past(level[IDX_PLAY])) |-> !report_o[IDX_PLAY] || $past(report_o[IDX_PLAY])); // R5

endmodule

// File: tb/btn_hid_ctrl_tb_top.sv
module btn_hid_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DB         = 4;
    localparam int SETTLE     = DB + 10;
    localparam int NVEC       = 16;

    // {btn[3:0]=vdn,vup,play,rec, susp, host_mute, exp_report[3:0], exp_stat,
    //  exp_ctrl[3:0]=pwr,stby,mute,bias, exp_strobes}
    localparam logic [15:0] VEC [NVEC] = '{
        {4'b0000, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b1001, 1'b0},
        {4'b0001, 1'b0, 1'b0, 4'b0001, 1'b1, 4'b1001, 1'b1},
        {4'b0000, 1'b0, 1'b0, 4'b0001, 1'b1, 4'b1001, 1'b0},
        {4'b0010, 1'b0, 1'b0, 4'b0011, 1'b1, 4'b1001, 1'b1},
        {4'b0110, 1'b0, 1'b0, 4'b0111, 1'b1, 4'b1001, 1'b1},
        {4'b0100, 1'b0, 1'b0, 4'b0101, 1'b1, 4'b1001, 1'b1},
        {4'b1100, 1'b0, 1'b0, 4'b1101, 1'b1, 4'b1001, 1'b1},
        {4'b0000, 1'b0, 1'b0, 4'b0001, 1'b1, 4'b1001, 1'b1},
        {4'b0001, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b1001, 1'b1},
        {4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0, 4'b1011, 1'b0},
        {4'b0001, 1'b0, 1'b1, 4'b0001, 1'b1, 4'b1011, 1'b1},
        {4'b0001, 1'b1, 1'b1, 4'b0001, 1'b0, 4'b0110, 1'b0},
        {4'b0000, 1'b1, 1'b0, 4'b0001, 1'b0, 4'b0110, 1'b0},
        {4'b0001, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b0110, 1'b1},
        {4'b0001, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b1001, 1'b0},
        {4'b0000, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b1001, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn = '0;
    logic       susp = 1'b0;
    logic       hmute = 1'b0;
    logic [3:0] report;
    logic       report_chg, stat, amp_pwr, amp_stby, amp_mute, mic_bias;
    int         n_vec = 0;
    int         n_err = 0;
    int         chg_cnt = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_hid_ctrl #(.DEBOUNCE_CYCLES(DB)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .btn_rec_mute_i  (btn[0]),
        .btn_play_mute_i (btn[1]),
        .btn_vol_up_i    (btn[2]),
        .btn_vol_down_i  (btn[3]),
        .suspend_i       (susp),
        .host_play_mute_i(hmute),
        .report_o        (report),
        .report_chg_o    (report_chg),
        .rec_mute_stat_o (stat),
        .amp_pwr_o       (amp_pwr),
        .amp_stby_o      (amp_stby),
        .amp_mute_o      (amp_mute),
        .mic_bias_en_o   (mic_bias)
    );

    always @(posedge clk) if (rst_n && report_chg) chg_cnt <= chg_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: state while in reset
        check("R1 report in reset", int'(report), 0);
        check("R1 strobe in reset", int'(report_chg), 0);
        check("R1 status in reset", int'(stat), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 report after reset", int'(report), 0);
        check("R1 status after reset", int'(stat), 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] w;
            w = VEC[v];
            btn   = w[15:12];
            susp  = w[11];
            hmute = w[10];
            base  = chg_cnt;
            settle();
            check("R2/R3 report", int'(report), int'(w[9:6]));
            check("R7/R10 status", int'(stat), int'(w[5]));
            check("R8/R9 amp ctrl", int'({amp_pwr, amp_stby, amp_mute, mic_bias}), int'(w[4:1]));
            check("R6/R5 strobe count", chg_cnt - base, int'(w[0]));
        end

        // R4: glitch one window short on record mute and playback mute
        base = chg_cnt;
        @(negedge clk);
        btn = 4'b0011;
        repeat (DB - 2) @(negedge clk);
        btn = 4'b0000;
        settle();
        check("R4 glitch report", int'(report), 0);
        check("R4 glitch strobe", chg_cnt - base, 0);

        // R5: inputs held low for a long time
        base = chg_cnt;
        repeat (SETTLE * 4) @(negedge clk);
        check("R5 idle strobe", chg_cnt - base, 0);
        check("R5 idle report", int'(report), 0);

        // R1: reset in the middle of operation clears state
        btn = 4'b0011;
        settle();
        check("R2 pre-reset report", int'(report), 3);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset report", int'(report), 0);
        check("R1 mid reset status", int'(stat), 0);
        btn = 4'b0000;
        rst_n = 1'b1;
        settle();
        check("R1 post reset report", int'(report), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule